// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Data Lookup

This block is the lookup stage of a level-one data cache. The set can be chosen before address translation has finished: the byte offset within a line and the set number are both taken from the untranslated page-offset bits of the virtual address. In the cycle a request's page-offset bits arrive, every way of the addressed set is read into registers. This covers the stored tag, the valid bit and the one 64-bit word the request wants. These reads overlap with the translation running elsewhere.

When the translated physical page number arrives on its strobe, the stored tags are compared against all of its bits. One cycle later the block reports hit or miss together with the selected word. A miss is only reported; fetching from lower levels is left to the caller.

A refill port writes a whole 64-byte line and its page-number tag into one set. The way it writes is chosen by a tree pseudo-LRU kept per set. The caller must keep to three rules:

- Raise the page-number strobe at least one cycle after the address strobe.
- Do not refill the set of a lookup that is still pending.
- Never refill a tag that the set already holds.

Top module: `vipt_dcache_lookup`

## Requirements
- R1: After reset, rsp_valid, rsp_hit and rsp_data are all zero. A page-number strobe given before any address strobe reports a miss.
- R2: va_idx[11:6] selects the set and is latched on va_valid. The latched set stays in use until the next va_valid, so a strobe that comes one, two or three cycles later is checked against the same set.
- R3: A lookup hits only when a way of the latched set is valid and its stored tag equals all 40 bits of ppn. A tag differing in any single bit, including bit 39 or bit 0, misses.
- R4: Every ppn_valid pulse yields rsp_valid high for exactly the following cycle. rsp_valid is low in every other cycle.
- R5: On a hit, rsp_data is word va_idx[5:3] of the matching line, where word k is fill_line bits 64k+63 down to 64k.
- R6: On a miss, rsp_hit is 0 and rsp_data is zero.
- R7: A refill marks the written way valid in set fill_set. The refill is visible to any lookup whose va_valid is in the cycle after the refill or later.
- R8: Each set keeps a 7-node pseudo-LRU tree, and both refills and hits mark the way they touch as most recent. In a freshly reset set with no hits, successive refills land in ways 0, 4, 2, 6, 1, 5, 3, 7, and the ninth refill replaces the first line written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| va_valid | input | 1 | Page-offset bits of a new lookup are present |
| va_idx | input | 9 | Virtual address bits 11..3: set number and word number |
| ppn_valid | input | 1 | Translated page number is present; triggers the compare |
| ppn | input | 40 | Translated physical page number |
| fill_valid | input | 1 | Write one line |
| fill_set | input | 6 | Set to refill |
| fill_tag | input | 40 | Physical page number stored as the tag |
| fill_line | input | 512 | Line contents, word k in bits 64k+63..64k |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_data | output | 64 | Selected word on hit, zero on miss |

## Verification
A corrupted valid bit or tag shows up as a wrong rsp_hit on the very next lookup of that set. A wrong word select or a damaged line shows up in rsp_data in the response cycle. A disturbed pseudo-LRU tree cannot be seen at once. It surfaces only at the next refill of that set, when the wrong line is evicted and a later lookup of a line that should still be present misses. The bench therefore fills whole sets, touches lines with hits, and then probes every tag it holds.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int PLRU_MAXW = 64;
  typedef logic [PLRU_MAXW-1:0] plru_vec_t;

  // Walk from root (node 1): bit 0 -> lower half, bit 1 -> upper half.
  function automatic int plru_pick(plru_vec_t tree, int lvl);
    int node;
    node = 1;
    for (int l = 0; l < lvl; l++) node = node * 2 + int'(tree[node]);
    return node - (1 << lvl);
  endfunction

  // Point every node on the path of 'way' away from it.
  function automatic plru_vec_t plru_mark(plru_vec_t tree, int lvl, int way);
    plru_vec_t r;
    int        node;
    logic      dir;
    r    = tree;
    node = 1;
    for (int l = 0; l < lvl; l++) begin
      dir     = way[lvl-1-l];
      r[node] = ~dir;
      node    = node * 2 + int'(dir);
    end
    return r;
  endfunction
endpackage

// File: rtl/vipt_way_store.sv
module vipt_way_store #(
  parameter  int SETS       = 64,
  parameter  int LINE_BYTES = 64,
  parameter  int WORD_W     = 64,
  parameter  int TAG_W      = 40,
  localparam int SET_W      = $clog2(SETS),
  localparam int LINE_W     = LINE_BYTES * 8,
  localparam int WSEL_W     = $clog2(LINE_W / WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WSEL_W-1:0] rd_wsel,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  output logic [TAG_W-1:0]  q_tag,
  output logic              q_vld,
  output logic [WORD_W-1:0] q_word
);
  logic [LINE_W-1:0] line_mem [SETS];
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [SETS-1:0]   vld_q;

  // Block-RAM style storage: no reset, registered read.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_mem[wr_set] <= wr_line;
      tag_mem[wr_set]  <= wr_tag;
    end
    if (rd_en) begin
      q_tag  <= tag_mem[rd_set];
      q_word <= line_mem[rd_set][int'(rd_wsel)*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      q_vld <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_set] <= 1'b1;
      if (rd_en) q_vld <= vld_q[rd_set];
    end
  end

  // R7: a written line is valid from the next cycle on
  p_fill_sets_valid_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[$past(wr_set)]);
endmodule

// File: rtl/vipt_plru.sv
module vipt_plru
  import vipt_pkg::*;
#(
  parameter  int SETS  = 64,
  parameter  int WAYS  = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int LVL   = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] victim_set,
  output logic [WAY_W-1:0] victim_way
);
  logic [WAYS-1:0] tree_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (touch_en) begin
      tree_q[touch_set] <= WAYS'(plru_mark(plru_vec_t'(tree_q[touch_set]), LVL, int'(touch_way)));
    end
  end

  always_comb victim_way = WAY_W'(plru_pick(plru_vec_t'(tree_q[victim_set]), LVL));

  // Checker state: the way just touched must not be the next victim.
  logic             chk_arm;
  logic [SET_W-1:0] chk_set;
  logic [WAY_W-1:0] chk_way;
  logic [WAY_W-1:0] chk_vic;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_arm <= 1'b0;
      chk_set <= '0;
      chk_way <= '0;
    end else begin
      chk_arm <= touch_en;
      chk_set <= touch_set;
      chk_way <= touch_way;
    end
  end
  always_comb chk_vic = WAY_W'(plru_pick(plru_vec_t'(tree_q[chk_set]), LVL));

  // R8: most recently touched way is never the victim
  p_touched_not_victim_r8: assert property (@(posedge clk) disable iff (rst)
    chk_arm |-> (chk_vic != chk_way));
endmodule

// File: rtl/vipt_tag_check.sv
module vipt_tag_check #(
  parameter int WAYS   = 8,
  parameter int TAG_W  = 40,
  parameter int WORD_W = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmp_en,
  input  logic [TAG_W-1:0]             cmp_tag,
  input  logic [WAYS-1:0][TAG_W-1:0]   way_tag,
  input  logic [WAYS-1:0]              way_vld,
  input  logic [WAYS-1:0][WORD_W-1:0]  way_word,
  output logic [WAYS-1:0]              match_vec,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [WORD_W-1:0]            rsp_data
);
  logic [WORD_W-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    for (int w = 0; w < WAYS; w++) begin
      match_vec[w] = way_vld[w] && (way_tag[w] == cmp_tag);
      sel_word     = sel_word | (way_word[w] & {WORD_W{match_vec[w]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= cmp_en;
      if (cmp_en) begin
        rsp_hit  <= |match_vec;
        rsp_data <= sel_word;
      end
    end
  end

  // R3: at most one way of a set matches a page number
  p_single_match_r3: assert property (@(posedge clk) disable iff (rst)
    cmp_en |-> $onehot0(match_vec));
  // R6: a miss carries no data
  p_miss_data_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_data == '0));
endmodule

// File: rtl/vipt_dcache_lookup.sv
module vipt_dcache_lookup #(
  parameter  int SETS       = 64,
  parameter  int WAYS       = 8,
  parameter  int LINE_BYTES = 64,
  parameter  int TAG_W      = 40,
  parameter  int WORD_W     = 64,
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int SET_W      = $clog2(SETS),
  localparam int PGOFF_W    = OFF_W + SET_W,
  localparam int BYTE_W     = $clog2(WORD_W / 8),
  localparam int LINE_W     = LINE_BYTES * 8,
  localparam int WAY_W      = $clog2(WAYS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      va_valid,
  input  logic [PGOFF_W-1:BYTE_W]   va_idx,
  input  logic                      ppn_valid,
  input  logic [TAG_W-1:0]          ppn,
  input  logic                      fill_valid,
  input  logic [SET_W-1:0]          fill_set,
  input  logic [TAG_W-1:0]          fill_tag,
  input  logic [LINE_W-1:0]         fill_line,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [WORD_W-1:0]         rsp_data
);
  logic [SET_W-1:0]             lat_set;
  logic [WAYS-1:0][TAG_W-1:0]   w_tag;
  logic [WAYS-1:0]              w_vld;
  logic [WAYS-1:0][WORD_W-1:0]  w_word;
  logic [WAYS-1:0]              match_vec;
  logic [WAY_W-1:0]             hit_way;
  logic [WAY_W-1:0]             victim;
  logic                         touch_en;
  logic [SET_W-1:0]             touch_set;
  logic [WAY_W-1:0]             touch_way;

  // Set number of the pending lookup, used for the replacement update on a hit.
  always_ff @(posedge clk) begin
    if (rst)           lat_set <= '0;
    else if (va_valid) lat_set <= va_idx[PGOFF_W-1:OFF_W];
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    vipt_way_store #(
      .SETS(SETS), .LINE_BYTES(LINE_BYTES), .WORD_W(WORD_W), .TAG_W(TAG_W)
    ) u_store (
      .clk     (clk),
      .rst     (rst),
      .rd_en   (va_valid),
      .rd_set  (va_idx[PGOFF_W-1:OFF_W]),
      .rd_wsel (va_idx[OFF_W-1:BYTE_W]),
      .wr_en   (fill_valid && (victim == WAY_W'(w))),
      .wr_set  (fill_set),
      .wr_tag  (fill_tag),
      .wr_line (fill_line),
      .q_tag   (w_tag[w]),
      .q_vld   (w_vld[w]),
      .q_word  (w_word[w])
    );
  end

  vipt_tag_check #(.WAYS(WAYS), .TAG_W(TAG_W), .WORD_W(WORD_W)) u_check (
    .clk       (clk),
    .rst       (rst),
    .cmp_en    (ppn_valid),
    .cmp_tag   (ppn),
    .way_tag   (w_tag),
    .way_vld   (w_vld),
    .way_word  (w_word),
    .match_vec (match_vec),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_data  (rsp_data)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (match_vec[w]) hit_way = WAY_W'(w);
  end

  // A refill takes the replacement update when it coincides with a hit.
  always_comb begin
    touch_en  = fill_valid || (ppn_valid && (|match_vec));
    touch_set = fill_valid ? fill_set : lat_set;
    touch_way = fill_valid ? victim   : hit_way;
  end

  vipt_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
    .clk        (clk),
    .rst        (rst),
    .touch_en   (touch_en),
    .touch_set  (touch_set),
    .touch_way  (touch_way),
    .victim_set (fill_set),
    .victim_way (victim)
  );

  // R4: one response per strobe, in the following cycle
  p_strobe_gives_rsp_r4: assert property (@(posedge clk) disable iff (rst)
    ppn_valid |=> rsp_valid);
  p_rsp_needs_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(ppn_valid));
endmodule

// File: tb/test_vipt_dcache_lookup.sv
`timescale 1ns/1ps
module test_vipt_dcache_lookup;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          va_valid = 1'b0;
  logic [11:3]   va_idx = '0;
  logic          ppn_valid = 1'b0;
  logic [39:0]   ppn = '0;
  logic          fill_valid = 1'b0;
  logic [5:0]    fill_set = '0;
  logic [39:0]   fill_tag = '0;
  logic [511:0]  fill_line = '0;
  logic          rsp_valid;
  logic          rsp_hit;
  logic [63:0]   rsp_data;

  always #2 clk = ~clk;  // 250 MHz

  vipt_dcache_lookup i_vipt_dcache_lookup (
    .clk(clk), .rst(rst), .va_valid(va_valid), .va_idx(va_idx),
    .ppn_valid(ppn_valid), .ppn(ppn), .fill_valid(fill_valid),
    .fill_set(fill_set), .fill_tag(fill_tag), .fill_line(fill_line),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data)
  );

  // Reference model
  logic [39:0]  m_tag  [64][8];
  bit           m_vld  [64][8];
  logic [511:0] m_line [64][8];
  logic [7:0]   m_tree [64];

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  function automatic int ref_victim(logic [7:0] t);
    int n;
    n = 1;
    repeat (3) n = (t[n]) ? 2*n + 1 : 2*n;
    return n - 8;
  endfunction

  function automatic logic [7:0] ref_touch(logic [7:0] t, int way);
    logic [7:0] r;
    int n;
    r = t;
    n = 1;
    for (int b = 2; b >= 0; b--) begin
      r[n] = !way[b];
      n = 2*n + (way[b] ? 1 : 0);
    end
    return r;
  endfunction

  function automatic logic [511:0] rand_line();
    logic [511:0] l;
    for (int i = 0; i < 16; i++) l[i*32 +: 32] = $urandom;
    return l;
  endfunction

  function automatic logic [39:0] rand_tag();
    return {8'($urandom), 32'($urandom)};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_fill(input int s, input logic [39:0] t, input logic [511:0] l);
    int v;
    @(negedge clk);
    fill_valid = 1'b1; fill_set = 6'(s); fill_tag = t; fill_line = l;
    v = ref_victim(m_tree[s]);
    m_tag[s][v] = t; m_vld[s][v] = 1'b1; m_line[s][v] = l;
    m_tree[s] = ref_touch(m_tree[s], v);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  function automatic bit present(int s, logic [39:0] t);
    for (int w = 0; w < 8; w++) if (m_vld[s][w] && m_tag[s][w] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic lookup(input int s, input int ws, input logic [39:0] t,
                        input int gap, input string req);
    logic exp_hit;
    logic [63:0] exp_data;
    int hw;
    exp_hit = 1'b0; exp_data = '0; hw = 0;
    for (int w = 0; w < 8; w++)
      if (m_vld[s][w] && m_tag[s][w] == t) begin
        exp_hit = 1'b1; hw = w; exp_data = m_line[s][w][ws*64 +: 64];
      end
    @(negedge clk);
    va_valid = 1'b1; va_idx = {6'(s), 3'(ws)};
    @(negedge clk);
    va_valid = 1'b0;
    repeat (gap - 1) @(negedge clk);
    ppn_valid = 1'b1; ppn = t;
    @(negedge clk);
    ppn_valid = 1'b0;
    check("R4", "rsp_valid", 64'(rsp_valid), 64'd1);
    check(req, "rsp_hit", 64'(rsp_hit), 64'(exp_hit));
    check(exp_hit ? "R5" : "R6", "rsp_data", rsp_data, exp_data);
    if (exp_hit) m_tree[s] = ref_touch(m_tree[s], hw);
  endtask

  initial begin
    logic [39:0]  ta;
    logic [511:0] la;
    logic [39:0]  pool [4][12];
    logic [39:0]  fresh [9];
    void'($urandom(32'd20240611));
    for (int s = 0; s < 64; s++) begin
      m_tree[s] = '0;
      for (int w = 0; w < 8; w++) begin m_vld[s][w] = 1'b0; m_tag[s][w] = '0; m_line[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state and lookup with no address
    check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1", "rsp_hit", 64'(rsp_hit), 64'd0);
    check("R1", "rsp_data", rsp_data, 64'd0);
    ppn_valid = 1'b1; ppn = 40'h0;
    @(negedge clk);
    ppn_valid = 1'b0;
    check("R1", "miss before any address", 64'(rsp_hit), 64'd0);
    check("R4", "rsp_valid after strobe", 64'(rsp_valid), 64'd1);
    @(negedge clk);
    check("R4", "rsp_valid single cycle", 64'(rsp_valid), 64'd0);

    // R7 / R5: fill then read every word
    ta = 40'h80_1234_5678;
    la = rand_line();
    do_fill(10, ta, la);
    for (int ws = 0; ws < 8; ws++) lookup(10, ws, ta, 1, "R7");

    // R3: single-bit tag differences miss
    lookup(10, 2, ta ^ (40'd1 << 39), 1, "R3");
    lookup(10, 2, ta ^ 40'd1, 1, "R3");
    // R2: other set with same tag misses; delayed strobe still hits
    lookup(11, 0, ta, 1, "R2");
    lookup(10, 5, ta, 3, "R2");
    lookup(10, 6, ta, 2, "R2");

    // R8: nine fills into a fresh set; the first one is evicted
    for (int i = 0; i < 9; i++) fresh[i] = {8'(i + 1), 32'($urandom)};
    for (int i = 0; i < 9; i++) do_fill(20, fresh[i], rand_line());
    lookup(20, 0, fresh[0], 1, "R8");
    check("R8", "first fill evicted", 64'(rsp_hit), 64'd0);
    for (int i = 1; i < 9; i++) begin
      lookup(20, i % 8, fresh[i], 1, "R8");
      check("R8", "later fill kept", 64'(rsp_hit), 64'd1);
    end

    // Random mix over four sets
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 12; k++) pool[s][k] = rand_tag();
    for (int it = 0; it < 400; it++) begin
      int s, k;
      s = $urandom_range(3);
      k = $urandom_range(11);
      if ($urandom_range(2) == 0 && !present(40 + s, pool[s][k]))
        do_fill(40 + s, pool[s][k], rand_line());
      else
        lookup(40 + s, $urandom_range(7), pool[s][k], $urandom_range(1, 3), "R8");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule